// File: doc/BRIEF.md
# Conversion Start and Power-Mode Sequencer

This block runs the digital timing of one successive-approximation conversion cycle from a system clock. A falling edge on the start line begins a conversion and raises busy for a fixed number of clock cycles. One cycle before busy drops, the block takes the code offered by a behavioural converter model on `stubCode` and holds it on `result`. A one-cycle `resultValid` pulse, issued in the cycle busy goes low, marks data-ready.

Around that cycle the block also handles the power states. A synchronous reset halts any conversion, requests the output bus to float and starts a recovery wait. A power-down request takes effect at once when idle, or is held off until the running conversion completes. If the start line is left low when a conversion ends, the core naps. To wake it, the start line must stay high for a minimum time before the next falling edge. Start edges that arrive during a recovery wait or too soon after a nap are dropped, and a sticky flag records them. All durations are parameters in clock cycles.

Top module: `convSequencer`

## Requirements
- R1: A falling edge on `startLine` (high at one clock edge, low at the next), accepted from the ready state, sets `busy` after that edge. `busy` then stays high for exactly `CONV_CYC` clock cycles.
- R2: Falling edges on `startLine` while `busy` is high neither restart nor lengthen the conversion, and they do not set `startErr`.
- R3: `result` takes the value of `stubCode` one cycle before `busy` falls. `resultValid` is high for exactly the first cycle with `busy` low, and `result` does not change in that cycle.
- R4: While `rst` is high, `busy` and `resultValid` are low, `busKill` is high, `result` is 0 and `startErr` is 0. A conversion halted by reset produces no `resultValid`. `busKill` stays high until the next conversion completes and then goes low.
- R5: After `rst` is released, start edges are refused for `RST_WAIT_CYC` cycles. A refused edge leaves `busy` low and sets `startErr`, which stays set until the next reset. After the wait, a start edge is accepted.
- R6: A power-down request (`pwrDownReq` high) that arrives during a conversion lets the conversion run to completion with a valid result. `corePowerOn` then goes low in the cycle `busy` falls.
- R7: While `corePowerOn` is low, start edges are ignored: `busy` stays low and `startErr` is unchanged.
- R8: After `pwrDownReq` is released, `corePowerOn` returns high and start edges are refused for `WAKE_CYC` cycles, with `startErr` set. After that, a start edge is accepted.
- R9: If `startLine` is low in the cycle a conversion ends, the core enters nap and `napOn` goes high. If `startLine` is high in that cycle, the block returns to ready with `napOn` low.
- R10: In nap, a falling edge starts a conversion only if `startLine` was high for at least `NAP_HIGH_CYC` consecutive clock edges before it. Otherwise the edge is dropped and `startErr` is set.
- R11: In nap, `napOn` drops one cycle after `startLine` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; halts conversion |
| startLine | input | 1 | Conversion start line; a falling edge requests a conversion |
| pwrDownReq | input | 1 | Power-down request, level sensitive |
| stubCode | input | CODE_W | Code from the behavioural converter model |
| busy | output | 1 | High while a conversion runs |
| resultValid | output | 1 | One-cycle data-ready pulse when busy falls |
| result | output | CODE_W | Latched conversion code |
| busKill | output | 1 | Request to float the output data bus |
| corePowerOn | output | 1 | Core power enable |
| napOn | output | 1 | Core nap control |
| startErr | output | 1 | Sticky flag for dropped start edges |

## Verification
On every cycle, the assertions check the following: busy rises only after a falling edge, busy lasts exactly the conversion length, the data-ready pulse coincides with busy falling while the result holds steady, and reset clears the outputs. They also check that the error flag is sticky and that busy never shows while powered down or napping. Only the bench scenarios can show which start edges are refused and which are accepted. That covers the reset and wake recovery windows, the nap-exit high time, deferred power-down, and the exact codes delivered against those pushed by the driver.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic [2:0] {
    ST_RECOVER,
    ST_IDLE,
    ST_CONVERT,
    ST_NAP,
    ST_PDOWN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadConv;
    logic loadRstWait;
    logic loadWakeWait;
    logic capture;
    logic clearResult;
  } seqStrobe_t;

endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int CODE_W       = 16,
  parameter int CONV_CYC     = 500,
  parameter int RST_WAIT_CYC = 697,
  parameter int WAKE_CYC     = 100,
  parameter int NAP_HIGH_CYC = 50
) (
  input  logic              clk,
  input  logic              startLine,
  input  logic [CODE_W-1:0] stubCode,
  input  seqStrobe_t        stb,
  output logic              tmrZero,
  output logic              tmrOne,
  output logic              highMet,
  output logic [CODE_W-1:0] result
);

  localparam int MAX_A   = (CONV_CYC > RST_WAIT_CYC) ? CONV_CYC : RST_WAIT_CYC;
  localparam int TMR_MAX = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX);
  localparam int HC_W    = $clog2(NAP_HIGH_CYC + 1);

  logic [TMR_W-1:0] tmr;
  logic [HC_W-1:0]  highCnt;
  logic [CODE_W-1:0] resultQ;

  // shared down-counter for conversion length and both recovery waits
  always_ff @(posedge clk) begin
    if (stb.loadRstWait)       tmr <= TMR_W'(RST_WAIT_CYC - 1);
    else if (stb.loadConv)     tmr <= TMR_W'(CONV_CYC - 1);
    else if (stb.loadWakeWait) tmr <= TMR_W'(WAKE_CYC - 1);
    else if (tmr != '0)        tmr <= tmr - 1'b1;
  end

  // consecutive edges with the start line high, saturating
  always_ff @(posedge clk) begin
    if (!startLine)                          highCnt <= '0;
    else if (highCnt != HC_W'(NAP_HIGH_CYC)) highCnt <= highCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.clearResult)  resultQ <= '0;
    else if (stb.capture) resultQ <= stubCode;
  end

  assign tmrZero = (tmr == '0);
  assign tmrOne  = (tmr == TMR_W'(1));
  assign highMet = (highCnt == HC_W'(NAP_HIGH_CYC));
  assign result  = resultQ;

endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startLine,
  input  logic       pwrDownReq,
  input  logic       tmrZero,
  input  logic       tmrOne,
  input  logic       highMet,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       resultValid,
  output logic       busKill,
  output logic       corePowerOn,
  output logic       napOn,
  output logic       startErr
);

  seqState_t st, stNext;
  logic startQ, fallEdge, convDone, dropEdge;
  logic rdyQ, killQ, errQ;

  assign fallEdge = startQ & ~startLine;

  always_comb begin
    stNext   = st;
    stb      = '0;
    convDone = 1'b0;
    dropEdge = 1'b0;
    stb.loadRstWait = rst;
    stb.clearResult = rst;
    case (st)
      ST_RECOVER: begin
        dropEdge = fallEdge;
        if (pwrDownReq)   stNext = ST_PDOWN;
        else if (tmrZero) stNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (pwrDownReq) stNext = ST_PDOWN;
        else if (fallEdge) begin
          stNext       = ST_CONVERT;
          stb.loadConv = 1'b1;
        end
      end
      ST_CONVERT: begin
        stb.capture = tmrOne;
        if (tmrZero) begin
          convDone = 1'b1;
          if (pwrDownReq)      stNext = ST_PDOWN;
          else if (!startLine) stNext = ST_NAP;
          else                 stNext = ST_IDLE;
        end
      end
      ST_NAP: begin
        if (pwrDownReq) stNext = ST_PDOWN;
        else if (fallEdge) begin
          if (highMet) begin
            stNext       = ST_CONVERT;
            stb.loadConv = 1'b1;
          end else begin
            dropEdge = 1'b1;
          end
        end
      end
      ST_PDOWN: begin
        if (!pwrDownReq) begin
          stNext           = ST_RECOVER;
          stb.loadWakeWait = 1'b1;
        end
      end
      default: stNext = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk) begin
    startQ <= startLine;
    if (rst) begin
      st    <= ST_RECOVER;
      rdyQ  <= 1'b0;
      killQ <= 1'b1;
      errQ  <= 1'b0;
    end else begin
      st   <= stNext;
      rdyQ <= convDone;
      if (convDone) killQ <= 1'b0;
      if (dropEdge) errQ  <= 1'b1;
    end
  end

  assign busy        = (st == ST_CONVERT);
  assign corePowerOn = (st != ST_PDOWN);
  assign napOn       = (st == ST_NAP) && !startQ;
  assign resultValid = rdyQ;
  assign busKill     = killQ;
  assign startErr    = errQ;

endmodule

// File: rtl/convSequencer.sv
module convSequencer
  import seqPkg::*;
#(
  parameter int CODE_W       = 16,
  parameter int CONV_CYC     = 500,
  parameter int RST_WAIT_CYC = 697,
  parameter int WAKE_CYC     = 100,
  parameter int NAP_HIGH_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startLine,
  input  logic              pwrDownReq,
  input  logic [CODE_W-1:0] stubCode,
  output logic              busy,
  output logic              resultValid,
  output logic [CODE_W-1:0] result,
  output logic              busKill,
  output logic              corePowerOn,
  output logic              napOn,
  output logic              startErr
);

  seqStrobe_t stb;
  logic tmrZero, tmrOne, highMet;

  seqControl u_ctl (
    .clk(clk), .rst(rst), .startLine(startLine), .pwrDownReq(pwrDownReq),
    .tmrZero(tmrZero), .tmrOne(tmrOne), .highMet(highMet), .stb(stb),
    .busy(busy), .resultValid(resultValid), .busKill(busKill),
    .corePowerOn(corePowerOn), .napOn(napOn), .startErr(startErr)
  );

  seqDatapath #(
    .CODE_W(CODE_W), .CONV_CYC(CONV_CYC), .RST_WAIT_CYC(RST_WAIT_CYC),
    .WAKE_CYC(WAKE_CYC), .NAP_HIGH_CYC(NAP_HIGH_CYC)
  ) u_dp (
    .clk(clk), .startLine(startLine), .stubCode(stubCode), .stb(stb),
    .tmrZero(tmrZero), .tmrOne(tmrOne), .highMet(highMet), .result(result)
  );

endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int CODE_W   = 16,
  parameter int CONV_CYC = 500
) (
  input logic              clk,
  input logic              rst,
  input logic              startLine,
  input logic              busy,
  input logic              resultValid,
  input logic [CODE_W-1:0] result,
  input logic              busKill,
  input logic              corePowerOn,
  input logic              napOn,
  input logic              startErr
);

  localparam int BC_W = $clog2(CONV_CYC + 2);
  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst)       busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R1: busy only rises after a high-then-low start line
  a_r1_rise_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(startLine) && $past(startLine, 2)));

  // R1, R2: busy lasts exactly the conversion length
  a_r2_fixed_length: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (busyCnt == BC_W'(CONV_CYC)));

  // R3: data-ready pulse sits on the busy fall
  a_r3_valid_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> resultValid);

  // R3: result steady while flagged valid
  a_r3_result_steady: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $stable(result));

  // R4: reset floats the bus and stops the conversion
  a_r4_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busKill && !busy && !resultValid && result == '0));

  // R5: error flag is sticky between resets
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(startErr)) |-> startErr);

  // R7: no conversion while powered down
  a_r7_pd_idle: assert property (@(posedge clk) disable iff (rst)
    !corePowerOn |-> !busy);

  // R9: nap only outside a conversion
  a_r9_nap_idle: assert property (@(posedge clk) disable iff (rst)
    napOn |-> (!busy && corePowerOn));

endmodule

bind convSequencer seqChecker #(.CODE_W(CODE_W), .CONV_CYC(CONV_CYC)) u_seqChecker (
  .clk(clk), .rst(rst), .startLine(startLine), .busy(busy),
  .resultValid(resultValid), .result(result), .busKill(busKill),
  .corePowerOn(corePowerOn), .napOn(napOn), .startErr(startErr)
);

// File: tb/test_convSequencer.sv
module test_convSequencer;

  localparam int CW    = 16;
  localparam int CONV  = 500;
  localparam int RWAIT = 697;
  localparam int WAKE  = 100;
  localparam int NAPHI = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startLine = 1'b1;
  logic pwrDownReq = 1'b0;
  logic [CW-1:0] stubCode = '0;
  logic busy, resultValid, busKill, corePowerOn, napOn, startErr;
  logic [CW-1:0] result;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] expQ[$];

  always #2.5 clk = ~clk;

  convSequencer #(
    .CODE_W(CW), .CONV_CYC(CONV), .RST_WAIT_CYC(RWAIT),
    .WAKE_CYC(WAKE), .NAP_HIGH_CYC(NAPHI)
  ) i_convSequencer (
    .clk(clk), .rst(rst), .startLine(startLine), .pwrDownReq(pwrDownReq),
    .stubCode(stubCode), .busy(busy), .resultValid(resultValid),
    .result(result), .busKill(busKill), .corePowerOn(corePowerOn),
    .napOn(napOn), .startErr(startErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: starts a conversion, pushes the expected code when one is due
  task automatic doConv(input logic [CW-1:0] code, input bit glitch,
                        input int pdAt, input bit endHigh);
    int n;
    @(negedge clk);
    startLine = 1'b0;
    stubCode  = code;
    expQ.push_back(code);
    @(negedge clk);
    check(busy === 1'b1, "R1 busy after fall", busy, 1);
    n = 0;
    while (busy === 1'b1 && n < CONV + 10) begin
      n++;
      if (glitch && n == 100) startLine = 1'b1;
      if (glitch && n == 110) startLine = 1'b0;
      if (n == pdAt) pwrDownReq = 1'b1;
      if (n == CONV - 20) startLine = endHigh;
      @(negedge clk);
    end
    check(n == CONV, "R1 busy length", n, CONV);
    check(resultValid === 1'b1, "R3 valid at busy fall", resultValid, 1);
    check(busKill === 1'b0, "R4 bus released after result", busKill, 0);
    @(negedge clk);
    check(resultValid === 1'b0, "R3 valid one cycle", resultValid, 0);
  endtask

  // monitor: pops expected codes as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && resultValid === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected result", result, 0);
        end else begin
          logic [CW-1:0] e;
          e = expQ.pop_front();
          check(result === e, "R3 result code", result, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset state
    tick(5);
    check(busy === 1'b0, "R4 reset busy", busy, 0);
    check(busKill === 1'b1, "R4 reset kill", busKill, 1);
    check(resultValid === 1'b0, "R4 reset valid", resultValid, 0);
    check(result === '0, "R4 reset result", result, 0);
    check(startErr === 1'b0, "R4 reset err", startErr, 0);
    rst = 1'b0;

    // edge inside reset recovery window
    tick(20);
    startLine = 1'b0;
    tick(1);
    check(busy === 1'b0, "R5 refused in recovery", busy, 0);
    check(startErr === 1'b1, "R5 error set", startErr, 1);
    startLine = 1'b1;
    tick(5);
    check(startErr === 1'b1, "R5 error sticky", startErr, 1);

    // reset clears error; wait out recovery
    rst = 1'b1;
    tick(3);
    check(startErr === 1'b0, "R4 reset clears err", startErr, 0);
    rst = 1'b0;
    tick(RWAIT + 5);

    // conversion with restart attempt, ends with start high
    doConv(16'h1234, 1'b1, -1, 1'b1);
    check(startErr === 1'b0, "R2 no error from restart", startErr, 0);
    check(napOn === 1'b0, "R9 idle when start high", napOn, 0);

    // conversion ending with start low -> nap
    tick(10);
    doConv(16'hBEEF, 1'b0, -1, 1'b0);
    tick(10);
    check(napOn === 1'b1, "R9 nap when start low", napOn, 1);

    // leave nap with a long enough high time
    startLine = 1'b1;
    tick(1);
    check(napOn === 1'b0, "R11 nap drops on high", napOn, 0);
    tick(NAPHI + 9);
    doConv(16'h0001, 1'b0, -1, 1'b0);
    check(startErr === 1'b0, "R10 good exit no error", startErr, 0);

    // too short a high time in nap
    tick(5);
    startLine = 1'b1;
    tick(20);
    startLine = 1'b0;
    tick(1);
    check(busy === 1'b0, "R10 short high refused", busy, 0);
    check(startErr === 1'b1, "R10 short high error", startErr, 1);
    startLine = 1'b1;

    // reset in the middle of a conversion
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(RWAIT + 5);
    startLine = 1'b0;
    stubCode  = 16'hDEAD;
    tick(100);
    check(busy === 1'b1, "R1 running before abort", busy, 1);
    rst = 1'b1;
    tick(1);
    check(busy === 1'b0, "R4 abort stops busy", busy, 0);
    check(busKill === 1'b1, "R4 abort kills bus", busKill, 1);
    check(result === '0, "R4 abort clears result", result, 0);
    tick(2);
    rst = 1'b0;
    startLine = 1'b1;
    tick(RWAIT + 5);
    check(busKill === 1'b1, "R4 kill held until result", busKill, 1);

    // power-down requested during conversion
    doConv(16'h8000, 1'b0, 50, 1'b1);
    tick(1);
    check(corePowerOn === 1'b0, "R6 powered down after conv", corePowerOn, 0);

    // ignored while powered down
    tick(5);
    startLine = 1'b0;
    tick(1);
    check(busy === 1'b0, "R7 no conv in power-down", busy, 0);
    check(startErr === 1'b0, "R7 no error in power-down", startErr, 0);
    startLine = 1'b1;
    tick(5);

    // wake recovery
    pwrDownReq = 1'b0;
    tick(1);
    check(corePowerOn === 1'b1, "R8 power back on", corePowerOn, 1);
    tick(20);
    startLine = 1'b0;
    tick(1);
    check(busy === 1'b0, "R8 refused in wake window", busy, 0);
    check(startErr === 1'b1, "R8 wake window error", startErr, 1);
    startLine = 1'b1;
    tick(WAKE + 5);
    doConv(16'h7FFF, 1'b0, -1, 1'b1);

    tick(5);
    check(expQ.size() == 0, "R3 all results seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule